// File: doc/BRIEF.md
# Transmit Packet Queue Controller

This block sits between a host register port and a MAC transmit engine and keeps an ordered queue of packet handles, not packet data. The host loads a handle into a packet-number register and issues an enqueue command, which copies that handle into the queue tail. After that the host has nothing to do until an interrupt fires. Whenever transmission is enabled, and in half-duplex mode the deferral logic reports that the medium may be used, the controller hands the head handle to the MAC with a one-cycle start pulse. It then waits for the MAC to report success or failure. Only one packet is with the MAC at a time.

On success the controller sends a one-cycle release strobe carrying the handle to the page allocator. It raises the queue-empty interrupt once nothing is left to send. On failure it raises the failure interrupt, drops transmit enable, halts the sequence and shows the failed handle on a status port. The host can then put the handle back, turn transmission on again and enqueue it again. All interrupt flags are sticky and are cleared by write-one-to-clear acknowledges.

The dispatch state machine has four states:
- IDLE waits for a dispatch opportunity.
- ISSUE pops the head and drives the start pulse.
- WAIT holds the packet until the MAC reports on it.
- HALT is entered after a failure.

It has these transitions:
- IDLE→ISSUE ("go": enabled, queue not empty, deferral satisfied).
- ISSUE→WAIT (always, after one cycle).
- WAIT→IDLE ("sent": success reported).
- WAIT→HALT ("abort": failure reported, which takes priority over success).
- HALT→IDLE ("resume": transmit enable set again).

Top module: `txq_ctrl`

## Requirements
- R1: An enqueue copies the value the packet-number register holds before that clock edge into the queue tail, and handles reach the MAC in the order they were enqueued.
- R2: A start pulse is issued only when transmit enable was 1, and it lasts exactly one cycle with mac_pnum holding the dispatched handle. The next start cannot come before the current packet is reported on. With the enable at 0, queued handles stay put.
- R3: With half_duplex at 1, no packet is dispatched while defer_ok is 0, and dispatch follows one cycle after defer_ok rises.
- R4: A success report (mac_done at 1, mac_fail at 0 while a packet is outstanding) drives rel_stb high in that same cycle, with rel_pnum equal to the completed handle. A failure produces no release.
- R5: irq_empty (ack bit 0) is set by a success that leaves the queue holding no handle. It is not set while further handles remain queued.
- R6: A failure report sets irq_fail (ack bit 1), clears transmit enable, and latches the failed handle on fail_pnum. No further start is issued until the host sets transmit enable again.
- R7: The queue holds 32 handles. An enqueue while 32 are held is dropped, leaves the held handles intact, and sets irq_ovf (ack bit 2).
- R8: Each interrupt flag stays set until its bit of irq_ack is written as 1. Acknowledging one flag leaves the others unchanged, and a new event in the same cycle as its acknowledge keeps the flag set.
- R9: After reset, transmit enable, all interrupt flags, mac_start, rel_stb and fail_pnum are 0, and the queue is empty.
- R10: After a failure, writing the failed handle back, enqueuing it and setting transmit enable resumes dispatch with the handles still queued, followed by the re-queued one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pnum_wr | input | 1 | Load the packet-number register |
| pnum_wdata | input | 6 | Value for the packet-number register |
| enq_cmd | input | 1 | Enqueue command: push the packet-number register into the queue |
| txen_wr | input | 1 | Write transmit enable |
| txen_wdata | input | 1 | New transmit enable value |
| irq_ack | input | 3 | Write-one-to-clear: bit 0 empty, bit 1 fail, bit 2 overflow |
| half_duplex | input | 1 | 1 makes dispatch wait for defer_ok |
| defer_ok | input | 1 | Deferral logic allows a transmission |
| mac_start | output | 1 | One-cycle start of a packet toward the MAC |
| mac_pnum | output | 6 | Handle of the packet given to the MAC |
| mac_done | input | 1 | MAC reports the outstanding packet was sent |
| mac_fail | input | 1 | MAC reports the outstanding packet failed |
| rel_stb | output | 1 | One-cycle page release strobe |
| rel_pnum | output | 6 | Handle whose pages are released |
| txen | output | 1 | Current transmit enable |
| fail_pnum | output | 6 | Handle of the last failed packet |
| irq_empty | output | 1 | Sticky queue-empty interrupt |
| irq_fail | output | 1 | Sticky transmit-failure interrupt |
| irq_ovf | output | 1 | Sticky enqueue-overflow interrupt |

## Verification
An enqueue caught at one edge adds to the queue at that edge, and the state machine leaves IDLE at the next edge. mac_start is therefore visible in the second cycle after the enqueue cycle. The same one-cycle gap holds from a rise of defer_ok or transmit enable. rel_stb follows mac_done in the same cycle, while the interrupt flags, txen and fail_pnum change at the edge that samples the MAC report. The bench drives inputs on the falling edge and samples either one falling edge after the deciding rising edge or, for the release strobe, shortly after driving the report. Where only the order matters, it polls for the start pulse within a bounded window.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_HALT  = 2'd3
    } txq_state_e;

    localparam int IRQ_N     = 3;
    localparam int IRQ_EMPTY = 0;
    localparam int IRQ_FAIL  = 1;
    localparam int IRQ_OVF   = 2;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int WIDTH = 6,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/txq_fsm.sv
module txq_fsm
    import txq_pkg::*;
#(
    parameter int PNUM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txen_wr,
    input  logic              txen_wdata,
    input  logic              half_duplex,
    input  logic              defer_ok,
    input  logic              q_empty,
    input  logic [PNUM_W-1:0] q_head,
    output logic              q_pop,
    output logic              mac_start,
    output logic [PNUM_W-1:0] mac_pnum,
    input  logic              mac_done,
    input  logic              mac_fail,
    output logic              rel_stb,
    output logic [PNUM_W-1:0] rel_pnum,
    output logic              txen,
    output logic [PNUM_W-1:0] fail_pnum,
    output logic              ev_empty,
    output logic              ev_fail,
    output logic              busy
);
    txq_state_e        state, state_nx;
    logic [PNUM_W-1:0] cur_pnum;
    logic              go, sent, abort;

    // transition conditions
    always_comb begin
        go    = (state == ST_IDLE) && txen && !q_empty && (!half_duplex || defer_ok);
        abort = (state == ST_WAIT) && mac_fail;
        sent  = (state == ST_WAIT) && mac_done && !mac_fail;
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go)    state_nx = ST_ISSUE;
            ST_ISSUE:            state_nx = ST_WAIT;
            ST_WAIT: begin
                if (abort)      state_nx = ST_HALT;
                else if (sent)  state_nx = ST_IDLE;
            end
            ST_HALT:  if (txen)  state_nx = ST_IDLE;
            default:             state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_pnum  <= '0;
            fail_pnum <= '0;
            txen      <= 1'b0;
        end else begin
            if (go)           cur_pnum  <= q_head;
            if (abort)        fail_pnum <= cur_pnum;
            if (abort)        txen      <= 1'b0;
            else if (txen_wr) txen      <= txen_wdata;
        end
    end

    // outputs
    always_comb begin
        q_pop     = go;
        mac_start = (state == ST_ISSUE);
        mac_pnum  = cur_pnum;
        busy      = (state == ST_WAIT);
        rel_stb   = sent;
        rel_pnum  = cur_pnum;
        ev_fail   = abort;
        ev_empty  = sent && q_empty;
    end
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] ack,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~ack) | set;
    end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int PNUM_W = 6,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pnum_wr,
    input  logic [PNUM_W-1:0] pnum_wdata,
    input  logic              enq_cmd,
    input  logic              txen_wr,
    input  logic              txen_wdata,
    input  logic [IRQ_N-1:0]  irq_ack,
    input  logic              half_duplex,
    input  logic              defer_ok,
    output logic              mac_start,
    output logic [PNUM_W-1:0] mac_pnum,
    input  logic              mac_done,
    input  logic              mac_fail,
    output logic              rel_stb,
    output logic [PNUM_W-1:0] rel_pnum,
    output logic              txen,
    output logic [PNUM_W-1:0] fail_pnum,
    output logic              irq_empty,
    output logic              irq_fail,
    output logic              irq_ovf
);
    logic [PNUM_W-1:0] pnum_reg;
    logic [PNUM_W-1:0] q_head;
    logic              q_empty, q_full, q_drop, q_pop;
    logic              ev_empty, ev_fail, busy;
    logic [IRQ_N-1:0]  irq_set, irq_flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pnum_reg <= '0;
        else if (pnum_wr) pnum_reg <= pnum_wdata;
    end

    txq_fifo #(.WIDTH(PNUM_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enq_cmd),
        .push_data (pnum_reg),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full),
        .drop      (q_drop)
    );

    txq_fsm #(.PNUM_W(PNUM_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .txen_wr     (txen_wr),
        .txen_wdata  (txen_wdata),
        .half_duplex (half_duplex),
        .defer_ok    (defer_ok),
        .q_empty     (q_empty),
        .q_head      (q_head),
        .q_pop       (q_pop),
        .mac_start   (mac_start),
        .mac_pnum    (mac_pnum),
        .mac_done    (mac_done),
        .mac_fail    (mac_fail),
        .rel_stb     (rel_stb),
        .rel_pnum    (rel_pnum),
        .txen        (txen),
        .fail_pnum   (fail_pnum),
        .ev_empty    (ev_empty),
        .ev_fail     (ev_fail),
        .busy        (busy)
    );

    always_comb begin
        irq_set            = '0;
        irq_set[IRQ_EMPTY] = ev_empty;
        irq_set[IRQ_FAIL]  = ev_fail;
        irq_set[IRQ_OVF]   = q_drop;
    end

    txq_irq #(.N(IRQ_N)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .ack   (irq_ack),
        .flags (irq_flags)
    );

    assign irq_empty = irq_flags[IRQ_EMPTY];
    assign irq_fail  = irq_flags[IRQ_FAIL];
    assign irq_ovf   = irq_flags[IRQ_OVF];
endmodule

// File: rtl/txq_ctrl_chk.sv
module txq_ctrl_chk #(
    parameter int PNUM_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enq_cmd,
    input logic [2:0]        irq_ack,
    input logic              half_duplex,
    input logic              defer_ok,
    input logic              mac_start,
    input logic [PNUM_W-1:0] mac_pnum,
    input logic              mac_done,
    input logic              mac_fail,
    input logic              rel_stb,
    input logic              txen,
    input logic [PNUM_W-1:0] fail_pnum,
    input logic              irq_empty,
    input logic              irq_fail,
    input logic              irq_ovf,
    input logic              q_full,
    input logic              busy
);
    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mac_start) |-> $past(txen));

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mac_start |=> !mac_start);

    p_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mac_start) |-> $past(!half_duplex || defer_ok));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_stb |=> (!busy && !mac_start));

    p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_empty) |-> $past(rel_stb));

    p_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mac_fail) |=> (!txen && irq_fail && fail_pnum == $past(mac_pnum)));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && enq_cmd) |=> irq_ovf);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_fail && !irq_ack[1]) |=> irq_fail);
endmodule

bind txq_ctrl txq_ctrl_chk #(.PNUM_W(PNUM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_cmd     (enq_cmd),
    .irq_ack     (irq_ack),
    .half_duplex (half_duplex),
    .defer_ok    (defer_ok),
    .mac_start   (mac_start),
    .mac_pnum    (mac_pnum),
    .mac_done    (mac_done),
    .mac_fail    (mac_fail),
    .rel_stb     (rel_stb),
    .txen        (txen),
    .fail_pnum   (fail_pnum),
    .irq_empty   (irq_empty),
    .irq_fail    (irq_fail),
    .irq_ovf     (irq_ovf),
    .q_full      (q_full),
    .busy        (busy)
);

// File: tb/tb_txq_ctrl.sv
`timescale 1ns/1ps
module tb_txq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pnum_wr = 1'b0;
    logic [5:0] pnum_wdata = '0;
    logic       enq_cmd = 1'b0;
    logic       txen_wr = 1'b0;
    logic       txen_wdata = 1'b0;
    logic [2:0] irq_ack = '0;
    logic       half_duplex = 1'b0;
    logic       defer_ok = 1'b0;
    logic       mac_done = 1'b0;
    logic       mac_fail = 1'b0;
    logic       mac_start, rel_stb, txen, irq_empty, irq_fail, irq_ovf;
    logic [5:0] mac_pnum, rel_pnum, fail_pnum;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    txq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pnum_wr(pnum_wr), .pnum_wdata(pnum_wdata),
        .enq_cmd(enq_cmd), .txen_wr(txen_wr), .txen_wdata(txen_wdata),
        .irq_ack(irq_ack), .half_duplex(half_duplex), .defer_ok(defer_ok),
        .mac_start(mac_start), .mac_pnum(mac_pnum), .mac_done(mac_done),
        .mac_fail(mac_fail), .rel_stb(rel_stb), .rel_pnum(rel_pnum),
        .txen(txen), .fail_pnum(fail_pnum), .irq_empty(irq_empty),
        .irq_fail(irq_fail), .irq_ovf(irq_ovf)
    );

    // vector: [7] MAC reports failure, [6] half duplex, [5:0] handle
    localparam logic [7:0] VEC [6] = '{8'h05, 8'h51, 8'hAA, 8'h3F, 8'hC0, 8'h61};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load(input logic [5:0] v);
        pnum_wr = 1'b1; pnum_wdata = v; tick(); pnum_wr = 1'b0;
        enq_cmd = 1'b1; tick(); enq_cmd = 1'b0;
    endtask

    task automatic set_txen(input logic v);
        txen_wr = 1'b1; txen_wdata = v; tick(); txen_wr = 1'b0;
    endtask

    task automatic ack(input logic [2:0] m);
        irq_ack = m; tick(); irq_ack = '0;
    endtask

    task automatic wait_start(input logic [5:0] exp, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 10 && !seen; i++) begin
            if (mac_start) seen = 1'b1;
            else tick();
        end
        chk({req, " start seen"}, int'(seen), 1);
        chk({req, " handle"}, int'(mac_pnum), int'(exp));
        tick();
    endtask

    // called in WAIT; drives the report, checks release, steps past the edge
    task automatic report(input bit fail, input logic [5:0] p);
        mac_done = !fail; mac_fail = fail;
        #1;
        chk("R4 rel_stb on report", int'(rel_stb), int'(!fail));
        if (!fail) chk("R4 rel_pnum", int'(rel_pnum), int'(p));
        tick();
        mac_done = 1'b0; mac_fail = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R9 reset state
        chk("R9 txen", int'(txen), 0);
        chk("R9 mac_start", int'(mac_start), 0);
        chk("R9 rel_stb", int'(rel_stb), 0);
        chk("R9 irq flags", int'({irq_ovf, irq_fail, irq_empty}), 0);
        chk("R9 fail_pnum", int'(fail_pnum), 0);

        // R2 gating: enable low holds queued handle
        load(6'd7);
        for (int i = 0; i < 4; i++) begin
            chk("R2 held while disabled", int'(mac_start), 0);
            tick();
        end
        set_txen(1'b1);
        chk("R2 no start yet", int'(mac_start), 0);
        tick();
        chk("R2 start after enable", int'(mac_start), 1);
        chk("R1 handle", int'(mac_pnum), 7);
        tick();
        report(1'b0, 6'd7);
        chk("R5 empty after single", int'(irq_empty), 1);
        ack(3'b111);

        // vector table
        for (int v = 0; v < 6; v++) begin
            logic       vf = VEC[v][7];
            logic       vh = VEC[v][6];
            logic [5:0] vp = VEC[v][5:0];
            half_duplex = vh; defer_ok = !vh;
            load(vp);
            if (vh) begin
                chk("R3 wait defer", int'(mac_start), 0);
                tick();
                chk("R3 wait defer", int'(mac_start), 0);
                defer_ok = 1'b1;
                tick();
                chk("R3 start after defer", int'(mac_start), 1);
            end else begin
                tick();
                chk("R1 start two cycles after enqueue", int'(mac_start), 1);
            end
            chk("R1 handle", int'(mac_pnum), int'(vp));
            tick();
            chk("R2 pulse one cycle", int'(mac_start), 0);
            report(vf, vp);
            if (vf) begin
                chk("R6 irq_fail", int'(irq_fail), 1);
                chk("R6 txen cleared", int'(txen), 0);
                chk("R6 fail_pnum", int'(fail_pnum), int'(vp));
                chk("R6 no empty on fail", int'(irq_empty), 0);
            end else begin
                chk("R5 irq_empty", int'(irq_empty), 1);
                chk("R5 no fail flag", int'(irq_fail), 0);
            end
            ack(3'b111);
            chk("R8 ack clears", int'({irq_ovf, irq_fail, irq_empty}), 0);
            if (vf) begin
                set_txen(1'b1);
                chk("R6 txen set again", int'(txen), 1);
            end
            half_duplex = 1'b0; defer_ok = 1'b0;
        end

        // R5 sequence: empty only after last
        set_txen(1'b0);
        load(6'd10);
        load(6'd11);
        set_txen(1'b1);
        wait_start(6'd10, "R1 order first");
        report(1'b0, 6'd10);
        chk("R5 not early", int'(irq_empty), 0);
        wait_start(6'd11, "R1 order second");
        report(1'b0, 6'd11);
        chk("R5 after last", int'(irq_empty), 1);
        ack(3'b001);

        // R6 / R10 failure with queued handles, restart
        set_txen(1'b0);
        load(6'd20);
        load(6'd21);
        load(6'd22);
        set_txen(1'b1);
        wait_start(6'd20, "R10 first");
        report(1'b1, 6'd20);
        chk("R6 txen cleared", int'(txen), 0);
        chk("R6 fail_pnum", int'(fail_pnum), 20);
        for (int i = 0; i < 4; i++) begin
            chk("R6 halted", int'(mac_start), 0);
            tick();
        end
        load(fail_pnum);
        ack(3'b010);
        set_txen(1'b1);
        wait_start(6'd21, "R10 resume");
        report(1'b0, 6'd21);
        wait_start(6'd22, "R10 resume");
        report(1'b0, 6'd22);
        chk("R5 not before requeued", int'(irq_empty), 0);
        wait_start(6'd20, "R10 requeued handle");
        report(1'b0, 6'd20);
        chk("R5 after requeued", int'(irq_empty), 1);

        // R7 overflow
        set_txen(1'b0);
        for (int i = 0; i < 32; i++) load(6'(i));
        chk("R7 no overflow at 32", int'(irq_ovf), 0);
        load(6'd50);
        chk("R7 overflow flag", int'(irq_ovf), 1);
        set_txen(1'b1);
        for (int i = 0; i < 32; i++) begin
            wait_start(6'(i), "R7 held intact");
            report(1'b0, 6'(i));
        end
        for (int i = 0; i < 4; i++) begin
            chk("R7 dropped handle absent", int'(mac_start), 0);
            tick();
        end

        // R8 partial acknowledge
        ack(3'b100);
        chk("R8 ovf cleared", int'(irq_ovf), 0);
        chk("R8 empty kept", int'(irq_empty), 1);
        tick();
        chk("R8 empty sticky", int'(irq_empty), 1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule